// File: doc/BRIEF.md
# Long-Instruction-Word Issue Unit

This block sits between an instruction fetch stream and five execution units. Each word it accepts is a long instruction word of either two or four 32-bit operations. The block captures one word into a holding register and works out which unit each operation slot goes to. It then hands every operation of that word to its unit in one and the same cycle. The five unit ports are integer 0, integer 1, floating point, load/store and branch.

The routing depends only on two fields of the first operation: a length bit and a three-bit format code. The block never looks at the operation bodies, never checks dependencies and never reorders anything. A word issues only when every unit it targets is ready. It therefore either goes out whole or waits whole. Words leave in the order they were accepted. If a word has a reserved format code, or its format would send two operations to the same unit, it is discarded and a one-cycle flag is raised.

Top module: `molecule_issue`

## Requirements
- R1: An accepted word (molValid and molReady both high at a rising edge) is held and presented to the units from the next cycle. molReady is high whenever no word is held.
- R2: Bit 0 of operation 0 selects the length: 0 means a short word, where only operations 0 and 1 (molData[63:0]) are used and molData[127:64] has no effect. 1 means a long word with operations 0 to 3. Operation k occupies molData[32k+31:32k].
- R3: Bits [3:1] of operation 0 form the format code. Unit numbers are 0=int0, 1=int1, 2=fp, 3=ls, 4=br. The units targeted by slots 0, 1, 2 and 3 for each code are: code 0 int0,int1,ls,br; code 1 int0,fp,ls,br; code 2 int0,int1,fp,ls; code 3 ls,int0,int1,br; code 4 fp,int0,empty,br; code 5 int0,br,int0,fp; code 6 br,empty,ls,empty. The routed operation appears whole on unitAtom[32u+31:32u] with unitValid[u] high.
- R4: A slot that is empty, or lies beyond the word's length, raises no valid to any unit. A word that targets no unit issues without waiting on any ready.
- R5: A held legal word issues (unitValid high on exactly its targeted units, for one cycle) only in a cycle where unitReady is high on every unit it targets. Readiness of units it does not target is ignored. Otherwise no unitValid is raised and the word stays held.
- R6: While a word is held and not issuing, molReady is low, so no later word is accepted ahead of it.
- R7: Bit 31 of each routed operation is its condition-code update flag and is driven on unitSetCc[u] together with unitValid[u].
- R8: A held word with code 7, or one whose live slots name the same unit twice (code 5 in a long word), raises illegalMol for one cycle. It raises no unitValid, is discarded in that cycle, and molReady is high in that cycle.
- R9: During and straight after reset, no unitValid and no illegalMol are asserted, and molReady is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| molValid | input | 1 | Fetch side offers a word |
| molReady | output | 1 | Block takes the offered word this cycle |
| molData | input | 128 | Offered word, operation k in bits [32k+31:32k] |
| unitReady | input | 5 | Per-unit ready (0 int0, 1 int1, 2 fp, 3 ls, 4 br) |
| unitValid | output | 5 | Per-unit operation valid |
| unitAtom | output | 160 | Per-unit operation, unit u in bits [32u+31:32u] |
| unitSetCc | output | 5 | Per-unit condition-code update flag |
| illegalMol | output | 1 | Held word discarded as illegal |

## Verification
Every format code is sent in both lengths with all units ready. This separates the slot maps from one another and shows the slot cut-off of short words. Short words also carry junk in their upper half, to show that it has no effect. Stall patterns withhold ready from one targeted unit while a second word is offered. These patterns tell all-or-nothing issue and in-order blocking apart from partial issue. Withholding ready from an untargeted unit tells a correct ready mask apart from a blanket wait. A long random run with random ready masks and random offers compares every cycle against a behavioural queue model, mixing legal, empty-slot and illegal words.

// File: rtl/mol_issue_pkg.sv
package mol_issue_pkg;

  localparam int ATOM_W      = 32;
  localparam int NUM_SLOTS   = 4;
  localparam int SHORT_SLOTS = 2;
  localparam int NUM_UNITS   = 5;
  localparam int FMT_W       = 3;
  localparam logic [FMT_W-1:0] FMT_RESERVED = 3'd7;

  typedef enum logic [2:0] {
    U_INT0 = 3'd0,
    U_INT1 = 3'd1,
    U_FP   = 3'd2,
    U_LS   = 3'd3,
    U_BR   = 3'd4,
    U_NONE = 3'd7
  } unit_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;   // capture the offered word
    logic issue;  // release the held word to its units
  } strobe_t;

  // fixed slot-to-unit map selected by the format code
  function automatic unit_e slotTarget(input logic [FMT_W-1:0] fmt, input int slot);
    unit_e m [NUM_SLOTS];
    case (fmt)
      3'd0:    m = '{U_INT0, U_INT1, U_LS,   U_BR};
      3'd1:    m = '{U_INT0, U_FP,   U_LS,   U_BR};
      3'd2:    m = '{U_INT0, U_INT1, U_FP,   U_LS};
      3'd3:    m = '{U_LS,   U_INT0, U_INT1, U_BR};
      3'd4:    m = '{U_FP,   U_INT0, U_NONE, U_BR};
      3'd5:    m = '{U_INT0, U_BR,   U_INT0, U_FP};
      3'd6:    m = '{U_BR,   U_NONE, U_LS,   U_NONE};
      default: m = '{U_NONE, U_NONE, U_NONE, U_NONE};
    endcase
    return m[slot];
  endfunction

endpackage

// File: rtl/mol_issue_dp.sv
module mol_issue_dp
  import mol_issue_pkg::*;
#(
  parameter int AtomW    = ATOM_W,
  parameter int NumSlots = NUM_SLOTS,
  parameter int NumUnits = NUM_UNITS
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [NumSlots*AtomW-1:0] molData,
  input  strobe_t                   strb,
  output logic [NumUnits-1:0]       unitTarget,
  output logic                      molLegal,
  output logic [NumUnits-1:0]       unitValid,
  output logic [NumUnits*AtomW-1:0] unitAtom,
  output logic [NumUnits-1:0]       unitSetCc
);

  localparam int CcBit = AtomW - 1;

  logic [NumSlots*AtomW-1:0] molReg;
  logic                      isLong;
  logic [FMT_W-1:0]          fmtCode;
  unit_e                     slotUnit [NumSlots];
  logic [NumSlots-1:0]       slotLive;
  logic [NumUnits-1:0][NumSlots-1:0] hitMat;
  logic [NumUnits-1:0]       unitConflict;

  always_ff @(posedge clk) begin
    if (!rstN)          molReg <= '0;
    else if (strb.load) molReg <= molData;
  end

  assign isLong  = molReg[0];
  assign fmtCode = molReg[FMT_W:1];

  for (genvar s = 0; s < NumSlots; s++) begin : g_slot
    localparam bit InShort = (s < SHORT_SLOTS);
    assign slotUnit[s] = slotTarget(fmtCode, s);
    assign slotLive[s] = (InShort || isLong) && (slotUnit[s] != U_NONE);
    for (genvar u = 0; u < NumUnits; u++) begin : g_hit
      assign hitMat[u][s] = slotLive[s] && (slotUnit[s] == unit_e'(3'(u)));
    end
  end

  for (genvar u = 0; u < NumUnits; u++) begin : g_unit
    logic [AtomW-1:0] routed;
    always_comb begin
      routed = '0;
      for (int s = 0; s < NumSlots; s++) begin
        if (hitMat[u][s]) routed = routed | molReg[s*AtomW +: AtomW];
      end
    end
    assign unitConflict[u] = (hitMat[u] & (hitMat[u] - NumSlots'(1))) != '0;
    assign unitTarget[u]   = |hitMat[u];
    assign unitValid[u]    = strb.issue & unitTarget[u];
    assign unitSetCc[u]    = unitValid[u] & routed[CcBit];
    assign unitAtom[u*AtomW +: AtomW] = routed;
  end

  assign molLegal = (fmtCode != FMT_RESERVED) && (unitConflict == '0);

  // R6: the held word does not change unless control loads a new one
  a_r6_hold_stable: assert property (@(posedge clk) disable iff (!rstN)
    !strb.load |=> $stable(molReg));

  // R8: control never releases a word that decodes as illegal
  a_r8_issue_legal: assert property (@(posedge clk) disable iff (!rstN)
    strb.issue |-> molLegal);

endmodule

// File: rtl/mol_issue_ctrl.sv
module mol_issue_ctrl
  import mol_issue_pkg::*;
#(
  parameter int NumUnits = NUM_UNITS
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                molValid,
  output logic                molReady,
  input  logic [NumUnits-1:0] unitReady,
  input  logic [NumUnits-1:0] unitTarget,
  input  logic                molLegal,
  output strobe_t             strb,
  output logic                illegalMol
);

  logic held;
  logic fire;
  logic drop;
  logic blocked;

  assign blocked    = (unitTarget & ~unitReady) != '0;
  assign fire       = held && molLegal && !blocked;
  assign drop       = held && !molLegal;
  assign molReady   = !held || fire || drop;
  assign illegalMol = drop;

  assign strb.load  = molValid && molReady;
  assign strb.issue = fire;

  always_ff @(posedge clk) begin
    if (!rstN)                held <= 1'b0;
    else if (strb.load)       held <= 1'b1;
    else if (fire || drop)    held <= 1'b0;
  end

  // R1: a handshake always leaves a word held for the next cycle
  a_r1_accept_held: assert property (@(posedge clk) disable iff (!rstN)
    (molValid && molReady) |=> held);

  // R6: a word that stays held keeps the fetch side stalled
  a_r6_stall_blocks: assert property (@(posedge clk) disable iff (!rstN)
    (held && !molReady) |=> held);

endmodule

// File: rtl/molecule_issue.sv
module molecule_issue
  import mol_issue_pkg::*;
#(
  parameter int AtomW    = ATOM_W,
  parameter int NumSlots = NUM_SLOTS,
  parameter int NumUnits = NUM_UNITS
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      molValid,
  output logic                      molReady,
  input  logic [NumSlots*AtomW-1:0] molData,
  input  logic [NumUnits-1:0]       unitReady,
  output logic [NumUnits-1:0]       unitValid,
  output logic [NumUnits*AtomW-1:0] unitAtom,
  output logic [NumUnits-1:0]       unitSetCc,
  output logic                      illegalMol
);

  strobe_t             strb;
  logic [NumUnits-1:0] unitTarget;
  logic                molLegal;

  mol_issue_ctrl #(.NumUnits(NumUnits)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .molValid   (molValid),
    .molReady   (molReady),
    .unitReady  (unitReady),
    .unitTarget (unitTarget),
    .molLegal   (molLegal),
    .strb       (strb),
    .illegalMol (illegalMol)
  );

  mol_issue_dp #(.AtomW(AtomW), .NumSlots(NumSlots), .NumUnits(NumUnits)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .molData    (molData),
    .strb       (strb),
    .unitTarget (unitTarget),
    .molLegal   (molLegal),
    .unitValid  (unitValid),
    .unitAtom   (unitAtom),
    .unitSetCc  (unitSetCc)
  );

  // R5: no unit ever sees a valid without its ready (no partial issue)
  a_r5_no_partial: assert property (@(posedge clk) disable iff (!rstN)
    (unitValid & ~unitReady) == '0);

  // R8: a discarded word reaches no unit
  a_r8_illegal_quiet: assert property (@(posedge clk) disable iff (!rstN)
    illegalMol |-> (unitValid == '0));

endmodule

// File: tb/molecule_issue_tb.sv
module molecule_issue_tb;

  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         molValid = 1'b0;
  logic         molReady;
  logic [127:0] molData = '0;
  logic [4:0]   unitReady = '0;
  logic [4:0]   unitValid;
  logic [159:0] unitAtom;
  logic [4:0]   unitSetCc;
  logic         illegalMol;

  int vectors = 0;
  int fails   = 0;
  logic [127:0] pend [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  molecule_issue u_dut (
    .clk(clk), .rstN(rstN), .molValid(molValid), .molReady(molReady),
    .molData(molData), .unitReady(unitReady), .unitValid(unitValid),
    .unitAtom(unitAtom), .unitSetCc(unitSetCc), .illegalMol(illegalMol)
  );

  // slot map from the requirement table, 7 = empty
  function automatic int mapOf(input int f, input int s);
    int t [4];
    case (f)
      0: t = '{0, 1, 3, 4};
      1: t = '{0, 2, 3, 4};
      2: t = '{0, 1, 2, 3};
      3: t = '{3, 0, 1, 4};
      4: t = '{2, 0, 7, 4};
      5: t = '{0, 4, 0, 2};
      6: t = '{4, 7, 3, 7};
      default: t = '{7, 7, 7, 7};
    endcase
    return t[s];
  endfunction

  function automatic logic [127:0] mkMol(input int f, input bit lng, input logic [3:0] cc);
    logic [127:0] m;
    for (int k = 0; k < 4; k++) m[32*k +: 32] = {cc[k], 31'($urandom)};
    m[3:0] = {3'(f), lng};
    return m;
  endfunction

  task automatic report(input string tag, input string what, input logic [159:0] act, input logic [159:0] exp);
    fails++;
    $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
  endtask

  // one clock of stimulus, comparison against the queue model, model update
  task automatic step(input bit v, input logic [127:0] d, input logic [4:0] rdy, input string tag);
    logic [127:0] m;
    int cnt [5];
    logic [31:0] atomE [5];
    bit lng, bad, ok, fire, drop, expReady;
    int f, nSlot, u;
    logic [4:0] expValid;
    @(negedge clk);
    molValid = v; molData = d; unitReady = rdy;
    #1;
    for (int i = 0; i < 5; i++) begin cnt[i] = 0; atomE[i] = '0; end
    fire = 0; drop = 0; expValid = '0;
    if (pend.size() != 0) begin
      m = pend[0];
      lng = m[0]; f = int'(m[3:1]);
      nSlot = lng ? 4 : 2;
      for (int s = 0; s < nSlot; s++) begin
        u = mapOf(f, s);
        if (u != 7) begin cnt[u]++; atomE[u] = m[32*s +: 32]; end
      end
      bad = (f == 7);
      ok = 1;
      for (int i = 0; i < 5; i++) begin
        if (cnt[i] > 1) bad = 1;
        if (cnt[i] != 0 && !rdy[i]) ok = 0;
      end
      drop = bad;
      fire = !bad && ok;
      if (fire) for (int i = 0; i < 5; i++) expValid[i] = (cnt[i] != 0);
    end
    expReady = (pend.size() == 0) || fire || drop;
    vectors++;
    if (molReady !== expReady) report({tag, " R6"}, "molReady", 160'(molReady), 160'(expReady));
    if (unitValid !== expValid) report({tag, " R5"}, "unitValid", 160'(unitValid), 160'(expValid));
    if (illegalMol !== drop) report({tag, " R8"}, "illegalMol", 160'(illegalMol), 160'(drop));
    for (int i = 0; i < 5; i++) begin
      if (expValid[i]) begin
        if (unitAtom[32*i +: 32] !== atomE[i])
          report({tag, " R3"}, $sformatf("unitAtom[%0d]", i), 160'(unitAtom[32*i +: 32]), 160'(atomE[i]));
        if (unitSetCc[i] !== atomE[i][31])
          report({tag, " R7"}, $sformatf("unitSetCc[%0d]", i), 160'(unitSetCc[i]), 160'(atomE[i][31]));
      end
    end
    if (fire || drop) void'(pend.pop_front());
    if (v && expReady) pend.push_back(d);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    logic [127:0] junk;
    // R9: outputs quiet while reset is held
    repeat (2) @(posedge clk);
    #1;
    vectors++;
    if (unitValid !== 5'b0 || illegalMol !== 1'b0 || molReady !== 1'b1)
      report("R9", "reset outputs", 160'({unitValid, illegalMol, molReady}), 160'(3'b001));
    @(negedge clk); rstN = 1'b1;
    step(0, '0, 5'h1f, "R9");

    // R1: single short word, presented the cycle after acceptance
    step(1, mkMol(0, 0, 4'b0001), 5'h1f, "R1");
    step(0, '0, 5'h1f, "R1");
    step(0, '0, 5'h1f, "R1");

    // R3: every code, long then short, back to back, all ready
    for (int f = 0; f < 7; f++) step(1, mkMol(f, 1, 4'(f * 5)), 5'h1f, "R3 long");
    for (int f = 0; f < 7; f++) step(1, mkMol(f, 0, 4'(f * 3)), 5'h1f, "R3 short");
    step(0, '0, 5'h1f, "R3");

    // R7: flag pattern variety on a four-unit word
    step(1, mkMol(1, 1, 4'b1010), 5'h1f, "R7");
    step(1, mkMol(1, 1, 4'b0101), 5'h1f, "R7");
    step(1, mkMol(2, 1, 4'b1111), 5'h1f, "R7");
    step(0, '0, 5'h1f, "R7");

    // R4: empty slots, and a short word whose only slots go to one unit
    step(1, mkMol(4, 1, 4'b0100), 5'h1f, "R4");
    step(1, mkMol(6, 1, 4'b1111), 5'h1f, "R4");
    step(1, mkMol(6, 0, 4'b0011), 5'h1f, "R4");
    step(0, '0, 5'h1f, "R4");

    // R2: short words with junk in the upper half
    for (int f = 0; f < 7; f++) begin
      junk = mkMol(f, 0, 4'b1100);
      junk[127:64] = {$urandom, $urandom};
      step(1, junk, 5'h1f, "R2");
    end
    step(0, '0, 5'h1f, "R2");

    // R5 and R6: load/store withheld while a second word is offered
    step(1, mkMol(0, 1, 4'b1001), 5'h1f, "R5");
    for (int i = 0; i < 3; i++) step(1, mkMol(3, 1, 4'b0110), 5'b10111, "R6 stall");
    step(1, mkMol(3, 1, 4'b0110), 5'h1f, "R6 release");
    step(0, '0, 5'h1f, "R6");
    step(0, '0, 5'h1f, "R6");
    // R5: untargeted fp not ready must not block code 0
    step(1, mkMol(0, 1, 4'b0011), 5'b11011, "R5 mask");
    step(0, '0, 5'b11011, "R5 mask");
    step(0, '0, 5'h1f, "R5");

    // R8: reserved code, long code 5 conflict, then a legal word
    step(1, mkMol(7, 1, 4'b1111), 5'h00, "R8");
    step(1, mkMol(5, 1, 4'b1111), 5'h00, "R8");
    step(1, mkMol(5, 0, 4'b0011), 5'h1f, "R8");
    step(0, '0, 5'h1f, "R8");
    step(0, '0, 5'h1f, "R8");

    // random mix, compared every cycle
    for (int i = 0; i < 4000; i++) begin
      logic [4:0] r;
      for (int b = 0; b < 5; b++) r[b] = ($urandom % 4) != 0;
      step(($urandom % 3) != 0, mkMol(int'($urandom % 8), 1'($urandom), 4'($urandom)), r, "R3 R5 random");
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule